// File: doc/BRIEF.md
# Load Miss Waiting Store

This block parks load requests whose target word is absent from the data cache, marked invalid, or still being fetched. The processor keeps issuing instructions after a miss. Each parked load keeps its word address and the number of the register it will write. A per-register reservation scoreboard is set while such a load is pending. The pipeline asks the scoreboard whether a register can be read, and it stalls only when a reservation blocks that read.

The memory side offers one returned word at a time, as an address and its data. Every parked load waiting for that address is completed, one per cycle, in the order the loads were parked. Each completion sends the register number and the returned data to the processor and drops that register's reservation. The return port stays stalled until the last matching load has been served. The number of parked loads is capped. When the store is full it refuses new misses, and it also refuses a miss aimed at a register that is already reserved.

Top module: `miss_wait_store`

## Requirements
- R1: After reset the store is empty. `missReady` and `retReady` are high, `cplValid` is low and `queryBusy` is low for every register.
- R2: A miss is accepted on a rising edge where `missValid` and `missReady` are both high. From the next cycle on, `queryBusy` reads 1 for its register.
- R3: A return whose address matches parked loads produces completions. In each one, `cplValid` goes high one cycle after the edge that serves the load, and `cplTag` and `cplData` carry the load's register and the returned data.
- R4: Loads that match one returned address are served one per cycle, oldest accepted first, whatever slots they occupy. `retReady` stays low while more than one match remains, so a return with k ≥ 1 matches is taken on its k-th cycle.
- R5: A return that matches no parked load is taken in its first cycle and produces no completion.
- R6: The reservation of a completed load is gone in the same cycle that its `cplValid` is high.
- R7: While a register is reserved, `missReady` is low for a miss that targets it. After that load completes, a miss to the register is accepted again.
- R8: The store holds at most ENTRIES loads (8 by default). While it is full, `missReady` is low. After one completion, a new miss is accepted.
- R9: A miss acceptance and a completion on the same edge both take effect. The new register becomes reserved and the completed one is released.
- R10: A parked load whose address differs from a return stays parked and completes later with its own return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | A missed load is offered |
| missReady | output | 1 | The store can take the offered miss |
| missAddr | input | ADDR_W | Word address of the missed load |
| missTag | input | log2(NUM_REGS) | Destination register of the missed load |
| retValid | input | 1 | Memory offers a returned word |
| retReady | output | 1 | The returned word is consumed on this edge |
| retAddr | input | ADDR_W | Address of the returned word |
| retData | input | DATA_W | Returned data |
| cplValid | output | 1 | A load completes this cycle |
| cplTag | output | log2(NUM_REGS) | Register written by the completing load |
| cplData | output | DATA_W | Data for that register |
| queryTag | input | log2(NUM_REGS) | Register the pipeline wants to read |
| queryBusy | output | 1 | That register still waits for a load |

## Verification
Parking a new miss and serving a parked one can happen on the same edge. Both change the entry array and the reservation scoreboard. The bench provokes this by raising `missValid` for a fresh register together with `retValid` for the address of a load that is already parked. It then judges the result through the scoreboard query port: the new register must read busy, the served one free, and the served completion must appear with the right data. The four-slot ordering case also frees a low slot and refills it. Age, not slot index, must then decide the delivery order.

// File: rtl/mws_pkg.sv
package mws_pkg;

  // Strobes sent from the control to the datapath each cycle.
  typedef struct packed {
    logic allocEn; // park the offered miss in the slot named by allocIdx
    logic freeEn;  // serve the oldest matching entry this cycle
  } mws_strobe_t;

endpackage

// File: rtl/mws_datapath.sv
module mws_datapath
  import mws_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 5,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mws_strobe_t       strb,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [TAG_W-1:0]  missTag,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [DATA_W-1:0] retData,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] matchVec,
  output logic [TAG_W-1:0]  oldestTag,
  output logic              cplValid,
  output logic [TAG_W-1:0]  cplTag,
  output logic [DATA_W-1:0] cplData
);

  logic [ADDR_W-1:0]  entAddr [ENTRIES];
  logic [TAG_W-1:0]   entTag  [ENTRIES];
  logic [ENTRIES-1:0] entValid;
  // olderThan[i][j] set: entry j was parked before entry i
  logic [ENTRIES-1:0] olderThan [ENTRIES];
  logic [ENTRIES-1:0] isOldest;
  logic [ENTRIES-1:0] freeMask;
  logic [IDX_W-1:0]   oldestIdx;

  assign validVec = entValid;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = entValid[g] && (entAddr[g] == retAddr);
    assign isOldest[g] = matchVec[g] && ((olderThan[g] & matchVec) == '0);
    assign freeMask[g] = strb.freeEn && isOldest[g];
  end

  always_comb begin
    oldestIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (isOldest[i]) oldestIdx = IDX_W'(i);
    end
  end

  assign oldestTag = entTag[oldestIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      cplValid <= 1'b0;
      cplTag   <= '0;
      cplData  <= '0;
    end else begin
      cplValid <= strb.freeEn;
      if (strb.freeEn) begin
        cplTag             <= oldestTag;
        cplData            <= retData;
        entValid[oldestIdx] <= 1'b0;
      end
      if (strb.allocEn) entValid[allocIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.allocEn) begin
      entAddr[allocIdx] <= missAddr;
      entTag[allocIdx]  <= missTag;
      for (int i = 0; i < ENTRIES; i++) begin
        if (i != int'(allocIdx)) olderThan[i][allocIdx] <= 1'b0;
      end
      olderThan[allocIdx] <= entValid & ~freeMask;
    end
  end

  // R8: a miss is only ever parked in an empty slot
  a_r8_alloc_empty_slot: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |-> !entValid[allocIdx]);

  // R3: serving an entry yields a completion carrying the returned data
  a_r3_cpl_follows_free: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeEn |=> (cplValid && cplData == $past(retData)));

  // R4: at most one matching entry is ever the oldest
  a_r4_single_oldest: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(isOldest));

endmodule

// File: rtl/mws_control.sv
module mws_control
  import mws_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 5,
  parameter int IDX_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               missValid,
  input  logic [TAG_W-1:0]   missTag,
  input  logic               retValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [TAG_W-1:0]   oldestTag,
  input  logic [TAG_W-1:0]   queryTag,
  output logic               missReady,
  output logic               retReady,
  output logic               queryBusy,
  output logic [IDX_W-1:0]   allocIdx,
  output mws_strobe_t        strb
);

  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [NUM_REGS-1:0] reserved;
  logic                haveFree;
  logic [CNT_W-1:0]    matchCnt;

  always_comb begin
    allocIdx = '0;
    haveFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        allocIdx = IDX_W'(i);
        haveFree = 1'b1;
      end
    end
  end

  always_comb begin
    matchCnt = '0;
    for (int i = 0; i < ENTRIES; i++) matchCnt = matchCnt + CNT_W'(matchVec[i]);
  end

  assign missReady    = haveFree && !reserved[missTag];
  assign retReady     = (matchCnt <= CNT_W'(1));
  assign queryBusy    = reserved[queryTag];
  assign strb.allocEn = missValid && missReady;
  assign strb.freeEn  = retValid && (matchCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reserved <= '0;
    end else begin
      if (strb.allocEn) reserved[missTag]   <= 1'b1;
      if (strb.freeEn)  reserved[oldestTag] <= 1'b0;
    end
  end

  // R2: an accepted miss leaves its register reserved
  a_r2_reserve_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> reserved[$past(missTag)]);

  // R6: a served load leaves its register free
  a_r6_reserve_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeEn |=> !reserved[$past(oldestTag)]);

  // R8: nothing is parked while every slot is occupied
  a_r8_full_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (&validVec) |-> !strb.allocEn);

endmodule

// File: rtl/miss_wait_store.sv
module miss_wait_store
  import mws_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int TAG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  output logic              missReady,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [TAG_W-1:0]  missTag,
  input  logic              retValid,
  output logic              retReady,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [DATA_W-1:0] retData,
  output logic              cplValid,
  output logic [TAG_W-1:0]  cplTag,
  output logic [DATA_W-1:0] cplData,
  input  logic [TAG_W-1:0]  queryTag,
  output logic              queryBusy
);

  mws_strobe_t        strb;
  logic [IDX_W-1:0]   allocIdx;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] matchVec;
  logic [TAG_W-1:0]   oldestTag;

  mws_control #(
    .ENTRIES(ENTRIES), .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missTag(missTag), .retValid(retValid),
    .validVec(validVec), .matchVec(matchVec), .oldestTag(oldestTag),
    .queryTag(queryTag), .missReady(missReady), .retReady(retReady),
    .queryBusy(queryBusy), .allocIdx(allocIdx), .strb(strb)
  );

  mws_datapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .allocIdx(allocIdx),
    .missAddr(missAddr), .missTag(missTag), .retAddr(retAddr), .retData(retData),
    .validVec(validVec), .matchVec(matchVec), .oldestTag(oldestTag),
    .cplValid(cplValid), .cplTag(cplTag), .cplData(cplData)
  );

endmodule

// File: tb/miss_wait_store_tb.sv
`timescale 1ns/1ps
module miss_wait_store_tb;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              missValid = 1'b0;
  logic              missReady;
  logic [ADDR_W-1:0] missAddr = '0;
  logic [TAG_W-1:0]  missTag = '0;
  logic              retValid = 1'b0;
  logic              retReady;
  logic [ADDR_W-1:0] retAddr = '0;
  logic [DATA_W-1:0] retData = '0;
  logic              cplValid;
  logic [TAG_W-1:0]  cplTag;
  logic [DATA_W-1:0] cplData;
  logic [TAG_W-1:0]  queryTag = '0;
  logic              queryBusy;

  int nRun = 0;
  int nFail = 0;
  logic [TAG_W-1:0]  expTag[$];
  logic [DATA_W-1:0] expData[$];

  always #10 clk = ~clk;

  miss_wait_store u_dut (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missReady(missReady), .missAddr(missAddr), .missTag(missTag),
    .retValid(retValid), .retReady(retReady), .retAddr(retAddr), .retData(retData),
    .cplValid(cplValid), .cplTag(cplTag), .cplData(cplData),
    .queryTag(queryTag), .queryBusy(queryBusy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_cpl(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    expTag.push_back(t);
    expData.push_back(d);
  endtask

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic issue_miss(input logic [ADDR_W-1:0] a, input logic [TAG_W-1:0] t);
    missValid = 1'b1; missAddr = a; missTag = t;
    #1;
    while (!missReady) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    missValid = 1'b0;
  endtask

  task automatic do_return(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input int expCyc, input string req);
    int cyc = 0;
    logic rdy;
    retValid = 1'b1; retAddr = a; retData = d;
    forever begin
      @(negedge clk); rdy = retReady; cyc++;
      @(posedge clk);
      if (rdy) break;
    end
    #1 retValid = 1'b0;
    chk(cyc == expCyc, req, cyc, expCyc);
  endtask

  function automatic bit busy(input logic [TAG_W-1:0] t);
    queryTag = t;
    return 1'b0;
  endfunction

  task automatic probe(input logic [TAG_W-1:0] t, input bit expBusy, input string req);
    queryTag = t;
    #1;
    chk(queryBusy == expBusy, req, queryBusy, expBusy);
  endtask

  // Monitor: pop expected completions as the design emits them.
  always @(negedge clk) begin
    if (rstN && cplValid) begin
      if (expTag.size() == 0) begin
        chk(1'b0, "R3 unexpected completion tag", cplTag, 0);
      end else begin
        logic [TAG_W-1:0]  t;
        logic [DATA_W-1:0] d;
        t = expTag.pop_front();
        d = expData.pop_front();
        chk(cplTag == t, "R4 completion tag/order", cplTag, t);
        chk(cplData == d, "R3 completion data", cplData, d);
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(missReady == 1'b1, "R1 missReady after reset", missReady, 1);
    chk(retReady == 1'b1, "R1 retReady after reset", retReady, 1);
    chk(cplValid == 1'b0, "R1 cplValid after reset", cplValid, 0);
    for (int r = 0; r < 32; r++) begin
      queryTag = TAG_W'(r);
      #0.1;
      chk(queryBusy == 1'b0, "R1 register reserved after reset", r, 0);
    end
    rstN = 1'b1;
    @(posedge clk); #1;

    // R2, R3, R6: a single miss and its return
    issue_miss(32'h40, 5'd3);
    probe(5'd3, 1'b1, "R2 register reserved after accept");
    expect_cpl(5'd3, 64'hAAAA_0001);
    do_return(32'h40, 64'hAAAA_0001, 1, "R3 single match accept cycle");
    probe(5'd3, 1'b0, "R6 reservation cleared with completion");

    // R5: unmatched return is consumed at once
    do_return(32'h999, 64'hDEAD, 1, "R5 unmatched return accept cycle");
    @(negedge clk);
    chk(cplValid == 1'b0, "R5 no completion for unmatched return", cplValid, 0);
    @(posedge clk); #1;

    // R7: second miss to a reserved register is refused
    issue_miss(32'h50, 5'd9);
    missValid = 1'b1; missAddr = 32'h60; missTag = 5'd9;
    #1;
    chk(missReady == 1'b0, "R7 miss to reserved register refused", missReady, 0);
    missValid = 1'b0;
    expect_cpl(5'd9, 64'hBBBB_0002);
    do_return(32'h50, 64'hBBBB_0002, 1, "R7 release return");
    missValid = 1'b1; missAddr = 32'h60; missTag = 5'd9;
    #1;
    chk(missReady == 1'b1, "R7 miss accepted after release", missReady, 1);
    missValid = 1'b0;
    issue_miss(32'h60, 5'd9);
    expect_cpl(5'd9, 64'hBBBB_0003);
    do_return(32'h60, 64'hBBBB_0003, 1, "R7 second load return");

    // R4, R10: age order across reused slots
    issue_miss(32'h300, 5'd1);
    issue_miss(32'h200, 5'd5);
    issue_miss(32'h301, 5'd2);
    expect_cpl(5'd1, 64'hC001);
    do_return(32'h300, 64'hC001, 1, "R10 first return");
    issue_miss(32'h200, 5'd6);
    issue_miss(32'h200, 5'd7);
    expect_cpl(5'd5, 64'hC200);
    expect_cpl(5'd6, 64'hC200);
    expect_cpl(5'd7, 64'hC200);
    do_return(32'h200, 64'hC200, 3, "R4 three matches accept cycle");
    probe(5'd2, 1'b1, "R10 unmatched entry still reserved");
    expect_cpl(5'd2, 64'hC301);
    do_return(32'h301, 64'hC301, 1, "R10 later return");

    // R8: capacity
    for (int i = 0; i < 8; i++) issue_miss(32'h100 + 32'(i * 8), TAG_W'(10 + i));
    missValid = 1'b1; missAddr = 32'h500; missTag = 5'd20;
    #1;
    chk(missReady == 1'b0, "R8 full store refuses miss", missReady, 0);
    missValid = 1'b0;
    expect_cpl(5'd10, 64'hF100);
    do_return(32'h100, 64'hF100, 1, "R8 free one slot");
    missValid = 1'b1; missAddr = 32'h500; missTag = 5'd20;
    #1;
    chk(missReady == 1'b1, "R8 miss accepted after a slot frees", missReady, 1);
    missValid = 1'b0;
    issue_miss(32'h500, 5'd20);
    for (int i = 1; i < 8; i++) begin
      expect_cpl(TAG_W'(10 + i), 64'hF100 + 64'(i));
      do_return(32'h100 + 32'(i * 8), 64'hF100 + 64'(i), 1, "R8 drain");
    end
    expect_cpl(5'd20, 64'hF500);
    do_return(32'h500, 64'hF500, 1, "R8 drain last");

    // R9: park and serve on the same edge
    issue_miss(32'h700, 5'd3);
    expect_cpl(5'd3, 64'hE700);
    missValid = 1'b1; missAddr = 32'h710; missTag = 5'd4;
    retValid = 1'b1; retAddr = 32'h700; retData = 64'hE700;
    #1;
    chk(missReady == 1'b1, "R9 miss ready in shared cycle", missReady, 1);
    chk(retReady == 1'b1, "R9 return ready in shared cycle", retReady, 1);
    @(posedge clk); #1;
    missValid = 1'b0; retValid = 1'b0;
    probe(5'd4, 1'b1, "R9 new register reserved");
    probe(5'd3, 1'b0, "R9 served register released");
    expect_cpl(5'd4, 64'hE710);
    do_return(32'h710, 64'hE710, 1, "R9 second return");

    repeat (3) @(posedge clk);
    chk(expTag.size() == 0, "R3 all expected completions delivered", expTag.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule